// File: doc/BRIEF.md
# Ethernet Transmit Deference Timer

This block decides the earliest moment an Ethernet MAC transmitter may begin a frame. It times the minimum inter-packet gap in nibble times. In half duplex it also defers to carrier on the medium. Time only advances on cycles where the nibble-time enable `tick_i` is high, so the same logic serves 10 and 100 Mb/s links.

Two gap flavours exist. The back-to-back gap follows the block's own transmission when no carrier has intervened. The non-back-to-back gap follows a period in which received carrier occupied the medium. The non-back-to-back gap is split at a programmable point. Carrier that appears before that point makes the block defer: it waits for the carrier to drop and then times the gap again from zero. Carrier that appears after that point is ignored. The block then completes the gap and grants transmission anyway, which may cause a collision but keeps access to the medium fair. In full duplex the carrier input plays no part. Every gap after a transmission is the back-to-back gap.

`tx_permit_o` is the grant. A frame starts at any clock edge where `tx_permit_o` and `tx_req_i` are both high. The transmitter reports the end of that frame with a one-cycle `tx_done_i` pulse.

Top module: `ifg_defer_timer`

## Requirements
- R1: While `rst_ni` is low, `tx_permit_o` and `deferring_o` are 0. After reset the block times a non-back-to-back gap, so with all gap fields at 0 in half duplex the permit follows 6 ticks.
- R2: In full duplex, the gap after `tx_done_i` lasts `gap_b2b_i`+3 ticks. `carrier_i` has no effect: there is no deferral and no change to the gap length.
- R3: In half duplex, when no carrier appears after `tx_done_i`, the gap lasts `gap_b2b_i`+6 ticks.
- R4: A back-to-back value of 0x15 in full duplex and a value of 0x12 in half duplex both give a gap of 24 ticks (96 bit times).
- R5: In half duplex, carrier during a back-to-back gap makes the block defer. Once the carrier drops, a non-back-to-back gap of `gap_nb2_i`+6 ticks is timed from zero.
- R6: In half duplex, carrier while fewer than min(`gap_nb1_i`, `gap_nb2_i`) ticks of a non-back-to-back gap have elapsed makes the block defer. The gap restarts from zero after the carrier drops.
- R7: Carrier that first appears once the window of R6 has elapsed is ignored. With a request pending, `tx_permit_o` rises after the full `gap_nb2_i`+6 ticks even though carrier is high.
- R8: When `gap_nb1_i` is larger than `gap_nb2_i`, the deferral window is `gap_nb2_i` ticks.
- R9: Cycles with `tick_i` low do not advance gap timing.
- R10: `tx_permit_o` rises in the cycle after the edge that samples the completing tick. It stays high until an edge where `tx_req_i` is high, and it is low from the next cycle. It stays low until a `tx_done_i` has been seen and a new gap has completed.
- R11: `deferring_o` is high exactly while the block is deferring and `tx_req_i` is high.
- R12: In half duplex, carrier while `tx_permit_o` is high and no request is pending withdraws the permit and starts a deferral. This also applies at the tick that completes a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One nibble time has passed |
| carrier_i | input | 1 | Carrier sense, already synchronous to `clk_i` |
| tx_req_i | input | 1 | Transmitter has a frame waiting |
| tx_done_i | input | 1 | One-cycle pulse at the end of the block's own frame |
| full_duplex_i | input | 1 | 1 selects full duplex, 0 selects half duplex |
| gap_b2b_i | input | GAP_W | Back-to-back gap field |
| gap_nb1_i | input | GAP_W | Carrier deferral window, in ticks |
| gap_nb2_i | input | GAP_W | Non-back-to-back gap field |
| tx_permit_o | output | 1 | Transmission may start |
| deferring_o | output | 1 | A pending request is held back by carrier |

## Verification
The assertions assume that the duplex bit and the gap fields stay still while a gap is being timed. Under that assumption the counter always stays below its target, and a full-duplex block never enters deferral. The bench therefore changes configuration only while the permit is high or while reset is held. The assertions also assume that `tx_done_i` arrives only after a granted start. In the directed parts the bench raises `tx_done_i` only after a start. In the random parts `tx_done_i` is driven freely, and the bench relies on its reference model, which ignores the pulse outside a transmission just as the requirements do.

// File: rtl/ifg_defer_pkg.sv
`timescale 1ns/1ps
package ifg_defer_pkg;
  typedef enum logic [1:0] {
    ST_GAP   = 2'd0,
    ST_READY = 2'd1,
    ST_TX    = 2'd2,
    ST_DEFER = 2'd3
  } ifg_state_e;

  localparam int unsigned FD_EXTRA = 3;
  localparam int unsigned HD_EXTRA = 6;
endpackage

// File: rtl/ifg_gap_sel.sv
`timescale 1ns/1ps
module ifg_gap_sel
  import ifg_defer_pkg::*;
#(
  parameter int unsigned GAP_W = 7,
  parameter int unsigned CNT_W = GAP_W + 1
) (
  input  logic             full_duplex_i,
  input  logic             short_i,
  input  logic [GAP_W-1:0] b2b_i,
  input  logic [GAP_W-1:0] nb1_i,
  input  logic [GAP_W-1:0] nb2_i,
  output logic [CNT_W-1:0] target_o,
  output logic [CNT_W-1:0] window_o,
  output logic             sense_all_o
);
  logic [GAP_W-1:0] nb1_eff;

  // window never exceeds the total gap
  assign nb1_eff = (nb1_i > nb2_i) ? nb2_i : nb1_i;

  always_comb begin
    if (full_duplex_i)
      target_o = CNT_W'(b2b_i) + CNT_W'(FD_EXTRA);
    else if (short_i)
      target_o = CNT_W'(b2b_i) + CNT_W'(HD_EXTRA);
    else
      target_o = CNT_W'(nb2_i) + CNT_W'(HD_EXTRA);
  end

  assign window_o    = (full_duplex_i || short_i) ? '0 : CNT_W'(nb1_eff);
  assign sense_all_o = !full_duplex_i && short_i;
endmodule

// File: rtl/ifg_tick_cnt.sv
`timescale 1ns/1ps
module ifg_tick_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] target_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (run_i && tick_i)   cnt_o <= cnt_o + CNT_W'(1);
  end

  assign done_o = run_i && tick_i && (cnt_o == target_i - CNT_W'(1));

  a_r9_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_o));

  a_r9_step_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_i && !clr_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  a_r3_below_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_o < target_i));
endmodule

// File: rtl/ifg_defer_timer.sv
`timescale 1ns/1ps
module ifg_defer_timer
  import ifg_defer_pkg::*;
#(
  parameter int unsigned GAP_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             carrier_i,
  input  logic             tx_req_i,
  input  logic             tx_done_i,
  input  logic             full_duplex_i,
  input  logic [GAP_W-1:0] gap_b2b_i,
  input  logic [GAP_W-1:0] gap_nb1_i,
  input  logic [GAP_W-1:0] gap_nb2_i,
  output logic             tx_permit_o,
  output logic             deferring_o
);
  localparam int unsigned CNT_W = GAP_W + 1;

  ifg_state_e       state_q, state_d;
  logic             short_q, short_d;
  logic [CNT_W-1:0] target, window, cnt;
  logic             sense_all, gap_done, crs_eff, in_window;

  ifg_gap_sel #(.GAP_W(GAP_W), .CNT_W(CNT_W)) u_sel (
    .full_duplex_i (full_duplex_i),
    .short_i       (short_q),
    .b2b_i         (gap_b2b_i),
    .nb1_i         (gap_nb1_i),
    .nb2_i         (gap_nb2_i),
    .target_o      (target),
    .window_o      (window),
    .sense_all_o   (sense_all)
  );

  ifg_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q != ST_GAP),
    .run_i    (state_q == ST_GAP),
    .tick_i   (tick_i),
    .target_i (target),
    .cnt_o    (cnt),
    .done_o   (gap_done)
  );

  assign crs_eff   = carrier_i && !full_duplex_i;
  assign in_window = sense_all || (cnt < window);

  always_comb begin
    state_d = state_q;
    short_d = short_q;
    unique case (state_q)
      ST_GAP: begin
        if (crs_eff && in_window)  state_d = ST_DEFER;
        else if (gap_done)         state_d = (crs_eff && !tx_req_i) ? ST_DEFER : ST_READY;
      end
      ST_READY: begin
        if (tx_req_i)              state_d = ST_TX;
        else if (crs_eff)          state_d = ST_DEFER;
      end
      ST_TX: begin
        if (tx_done_i) begin
          state_d = ST_GAP;
          short_d = 1'b1;
        end
      end
      ST_DEFER: begin
        if (!carrier_i) begin
          state_d = ST_GAP;
          short_d = 1'b0;
        end
      end
      default: state_d = ST_GAP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_GAP;
      short_q <= 1'b0;
    end else begin
      state_q <= state_d;
      short_q <= short_d;
    end
  end

  assign tx_permit_o = (state_q == ST_READY);
  assign deferring_o = (state_q == ST_DEFER) && tx_req_i;

  a_r10_permit_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_permit_o && tx_req_i) |=> !tx_permit_o);

  a_r10_permit_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_permit_o && !tx_req_i && !crs_eff) |=> tx_permit_o);

  a_r9_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_permit_o) |-> $past(tick_i));

  a_r2_fd_never_defers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_duplex_i && state_q != ST_DEFER) |=> (state_q != ST_DEFER));

  a_r6_hold_while_carrier: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEFER && carrier_i) |=> !tx_permit_o);
endmodule

// File: tb/ifg_defer_timer_test.sv
`timescale 1ns/1ps
module ifg_defer_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, crs = 1'b0, req = 1'b0, done = 1'b0, fd = 1'b0;
  logic [6:0] b2b = '0, nb1 = '0, nb2 = '0;
  logic permit, defer;

  int n_chk = 0, n_fail = 0;
  int tick_div = 1, tick_rand = 0, dcnt = 0;
  bit finished = 0;

  // reference model state: 0 gap, 1 ready, 2 own frame, 3 deferring
  int m_phase = 0, m_el = 0;
  bit m_short = 0;

  always #2.5 clk = ~clk;

  ifg_defer_timer #(.GAP_W(7)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .carrier_i(crs),
    .tx_req_i(req), .tx_done_i(done), .full_duplex_i(fd),
    .gap_b2b_i(b2b), .gap_nb1_i(nb1), .gap_nb2_i(nb2),
    .tx_permit_o(permit), .deferring_o(defer)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (tick_rand != 0) tick = ($urandom % 2) == 1;
    else begin
      tick = (dcnt == 0);
      dcnt = (dcnt + 1 >= tick_div) ? 0 : dcnt + 1;
    end
  end

  always @(posedge clk) begin
    int need, win;
    if (!rst_n) begin
      m_phase = 0; m_el = 0; m_short = 0;
    end else begin
      need = fd ? b2b + 3 : (m_short ? b2b + 6 : nb2 + 6);
      win  = (fd || m_short) ? 0 : ((nb1 < nb2) ? nb1 : nb2);
      case (m_phase)
        2: if (done) begin m_phase = 0; m_el = 0; m_short = 1; end
        1: if (req) m_phase = 2; else if (!fd && crs) m_phase = 3;
        3: if (!crs) begin m_phase = 0; m_el = 0; m_short = 0; end
        default: begin
          if (!fd && crs && (m_short || m_el < win)) m_phase = 3;
          else if (tick) begin
            if (m_el + 1 == need) m_phase = (!fd && crs && !req) ? 3 : 1;
            else m_el++;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check(permit == (m_phase == 1), "model tx_permit_o (R2,R3,R5,R6,R7,R10,R12)", permit, m_phase == 1);
      check(defer == (m_phase == 3 && req), "model deferring_o (R11)", defer, m_phase == 3 && req);
    end
  end

  task automatic measure(output int ticks, output int cycles);
    ticks = 0; cycles = 0;
    do begin
      @(posedge clk);
      if (tick) ticks++;
      cycles++;
      #1;
    end while (!permit && cycles < 2000);
  endtask

  task automatic wait_ticks(input int k);
    int n = 0;
    while (n < k) begin
      @(posedge clk);
      if (tick) n++;
    end
    @(negedge clk);
  endtask

  task automatic end_frame();
    @(negedge clk); req = 0; done = 1;
    @(negedge clk); done = 0;
  endtask

  task automatic start_frame();
    @(negedge clk); req = 1;
    end_frame();
  endtask

  task automatic leave_defer();
    @(negedge clk); crs = 0; req = 0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(5 * 150000);
    check(0, "watchdog (R10)", 0, 1);
    report();
  end

  initial begin
    int t, c;
    @(negedge clk); @(negedge clk);
    #1;
    check(permit == 0, "R1 permit in reset", permit, 0);
    check(defer == 0, "R1 defer in reset", defer, 0);
    rst_n = 1;
    measure(t, c);
    check(t == 6, "R1 first gap ticks", t, 6);

    fd = 1; b2b = 7'h15;
    start_frame(); measure(t, c);
    check(t == 24, "R4 full duplex 0x15 ticks", t, 24);

    b2b = 7'd5;
    start_frame(); crs = 1; measure(t, c);
    check(t == 8, "R2 full duplex gap with carrier", t, 8);
    check(defer == 0, "R2 no deferral", defer, 0);
    @(negedge clk); crs = 0;

    fd = 0; b2b = 7'h12; nb1 = 7'd12; nb2 = 7'd18;
    start_frame(); measure(t, c);
    check(t == 24, "R4 half duplex 0x12 ticks", t, 24);
    check(t == 24, "R3 half duplex back-to-back", t, 24);

    start_frame(); crs = 1; req = 1;
    repeat (4) @(negedge clk);
    #1;
    check(defer == 1, "R11 defer with request", defer, 1);
    check(permit == 0, "R5 no permit while deferring", permit, 0);
    leave_defer(); measure(t, c);
    check(t == 24, "R5 non-back-to-back after carrier", t, 24);

    start_frame(); crs = 1; leave_defer();
    wait_ticks(5); crs = 1; req = 1;
    @(negedge clk); #1;
    check(defer == 1, "R6 carrier inside window defers", defer, 1);
    leave_defer(); measure(t, c);
    check(t == 24, "R6 restart from zero", t, 24);

    start_frame(); crs = 1; leave_defer();
    wait_ticks(14); crs = 1; req = 1;
    measure(t, c);
    check(t == 10, "R7 remaining ticks after window", t, 10);
    check(permit == 1, "R7 permit despite carrier", permit, 1);
    @(negedge clk);
    end_frame(); crs = 0;
    measure(t, c);

    nb1 = 7'd30; nb2 = 7'd10;
    start_frame(); crs = 1; leave_defer();
    wait_ticks(11); crs = 1; req = 1;
    measure(t, c);
    check(t == 5, "R8 window clamped to part 2", t, 5);
    check(permit == 1, "R8 permit with carrier", permit, 1);
    @(negedge clk);
    end_frame(); crs = 0;
    measure(t, c);

    @(negedge clk); crs = 1;
    @(negedge clk); req = 1; #1;
    check(permit == 0, "R12 permit withdrawn", permit, 0);
    check(defer == 1, "R12 deferring", defer, 1);
    leave_defer(); measure(t, c);
    check(t == 16, "R12 gap after deferral", t, 16);

    tick_div = 3;
    b2b = 7'h12;
    start_frame(); measure(t, c);
    check(t == 24, "R9 ticks with sparse enable", t, 24);
    check(c >= 70, "R9 cycles with sparse enable", c, 70);
    tick_div = 1;

    repeat (10) begin
      @(negedge clk); #1;
      check(permit == 1, "R10 permit held", permit, 1);
    end
    @(negedge clk); req = 1;
    @(negedge clk); req = 0; #1;
    check(permit == 0, "R10 permit cleared on start", permit, 0);
    repeat (5) begin
      @(negedge clk); #1;
      check(permit == 0, "R10 low during frame", permit, 0);
    end
    end_frame(); measure(t, c);

    for (int pass = 0; pass < 2; pass++) begin
      do_reset();
      fd = (pass == 1); b2b = 7'h12; nb1 = 7'd12; nb2 = 7'd18;
      tick_rand = 1;
      repeat (3000) begin
        @(negedge clk);
        if (($urandom % 12) == 0) crs = !crs;
        req  = ($urandom % 4) != 0;
        done = ($urandom % 6) == 0;
      end
      @(negedge clk); crs = 0; req = 0; done = 0; tick_rand = 0;
    end
    repeat (3) @(negedge clk);
    report();
  end
endmodule